// File: doc/BRIEF.md
# Two-Phase Multiplexed Display Latch Controller

The block refreshes a multiplexed LED readout that mixes 7-segment digits, a dual 14-segment unit and annunciator groups. A divider turns the system clock into a phase tick, 1024 cycles by default, which gives 640 Hz from a 655.36 kHz clock. The controller alternates between two segment latches, one per phase. At the start of each first-latch phase it raises an interrupt. The host answers it by writing the segment patterns for the next digit pair into the two latches and giving the base pair index.

While a latch is being shown, its segment pattern drives the shared segment bus and the matching one-hot digit-select line is active. The selects are blanked for a short window around every phase change so that no digit shows its neighbour's pattern. A host write or a change of the pair index never alters the pattern or the digit being shown. It takes effect at the next phase boundary.

Top module: `disp_mux_ctrl`

## Requirements
- R1: While reset is asserted, and just after it is released, seg_o is all zero, dsel_o is all zero and irq_o is low.
- R2: Each phase lasts exactly DIV clock cycles. Phases alternate strictly between first-latch (phase value 0) and second-latch (phase value 1). The phase after reset is the second-latch phase.
- R3: At each phase start, seg_o loads the latch that belongs to the new phase and holds it for the whole phase. A write with wr_sel_i=0 targets the first latch and a write with wr_sel_i=1 targets the second latch. The bus is SEG_W (at least 14) bits wide.
- R4: Outside blanking, dsel_o is one-hot with bit i selecting digit i. It selects digit 2*base during a first-latch phase and digit 2*base+1 during a second-latch phase, where base is the value of base_pair_i sampled at that phase's start.
- R5: dsel_o is all zero during the first BLANK/2 and the last BLANK/2 cycles of every phase.
- R6: irq_o rises on the clock edge that starts each first-latch phase, so it fires once per digit pair. It stays high until acknowledged.
- R7: irq_ack_i held high on a clock edge clears irq_o. If the acknowledge arrives on the edge that starts a first-latch phase, the set wins and irq_o stays high.
- R8: Latch writes and changes of base_pair_i made during a phase leave seg_o and dsel_o unchanged until the next phase start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Latch write strobe |
| wr_sel_i | input | 1 | Latch address: 0 first, 1 second |
| wr_data_i | input | SEG_W | Segment pattern to write |
| base_pair_i | input | log2(DIGITS/2) | Digit-pair index for the next phases |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| seg_o | output | SEG_W | Segment bus |
| dsel_o | output | DIGITS | One-hot digit selects |
| irq_o | output | 1 | Refresh interrupt |

## Verification
The assertions check on every cycle that:
- the selects are never more than one-hot;
- the phase flips on every tick and the selects are blanked right after it;
- the segment bus stays frozen between ticks;
- the interrupt is set, held and cleared with the stated priority.

Only the bench scenarios can show which digit lights for a given base index and which written pattern appears in which phase. They also show that the blanking covers both ends of the phase, and that mid-phase writes and index changes appear exactly one phase later.

// File: rtl/disp_mux_pkg.sv
package disp_mux_pkg;
  typedef enum logic {PH_FIRST = 1'b0, PH_SECOND = 1'b1} phase_e;
endpackage

// File: rtl/disp_tick_div.sv
module disp_tick_div #(
  parameter int DIV        = 1024,
  parameter int HALF_BLANK = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o,
  output logic blank_o
);
  localparam int CNT_W = $clog2(DIV);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o  = (cnt_q == CNT_W'(DIV - 1));
  assign blank_o = (cnt_q < CNT_W'(HALF_BLANK)) || (cnt_q >= CNT_W'(DIV - HALF_BLANK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/disp_seg_latch.sv
module disp_seg_latch #(
  parameter int SEG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [SEG_W-1:0] wr_data_i,
  input  logic             load_i,
  input  logic             load_sel_i,
  output logic [SEG_W-1:0] seg_o
);
  logic [SEG_W-1:0] stage_q [2];
  logic [SEG_W-1:0] seg_q;

  for (genvar i = 0; i < 2; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             stage_q[i] <= '0;
      else if (wr_en_i && (wr_sel_i == 1'(i))) stage_q[i] <= wr_data_i;
    end
  end

  // shown pattern only moves on a phase boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seg_q <= '0;
    else if (load_i) seg_q <= stage_q[load_sel_i];
  end

  assign seg_o = seg_q;
endmodule

// File: rtl/disp_sel_dec.sv
module disp_sel_dec #(
  parameter int DIGITS = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             load_i,
  input  logic [$clog2(DIGITS/2)-1:0]      base_i,
  input  logic                             phase_i,
  input  logic                             blank_i,
  output logic [DIGITS-1:0]                dsel_o
);
  localparam int IDX_W = $clog2(DIGITS);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= IDX_W'(1);
    else if (load_i) idx_q <= {base_i, phase_i};
  end

  assign dsel_o = blank_i ? '0 : (DIGITS'(1) << idx_q);
endmodule

// File: rtl/disp_mux_ctrl.sv
module disp_mux_ctrl
  import disp_mux_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int DIGITS = 8,
  parameter int DIV    = 1024,
  parameter int BLANK  = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic                        wr_sel_i,
  input  logic [SEG_W-1:0]            wr_data_i,
  input  logic [$clog2(DIGITS/2)-1:0] base_pair_i,
  input  logic                        irq_ack_i,
  output logic [SEG_W-1:0]            seg_o,
  output logic [DIGITS-1:0]           dsel_o,
  output logic                        irq_o
);
  localparam int HALF_BLANK = BLANK / 2;

  logic   tick;
  logic   blank;
  phase_e phase_q;
  phase_e phase_nxt;
  logic   irq_q;

  assign phase_nxt = (phase_q == PH_FIRST) ? PH_SECOND : PH_FIRST;

  disp_tick_div #(.DIV(DIV), .HALF_BLANK(HALF_BLANK)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_o  (tick),
    .blank_o (blank)
  );

  disp_seg_latch #(.SEG_W(SEG_W)) u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .load_i     (tick),
    .load_sel_i (phase_nxt),
    .seg_o      (seg_o)
  );

  disp_sel_dec #(.DIGITS(DIGITS)) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tick),
    .base_i  (base_pair_i),
    .phase_i (phase_nxt),
    .blank_i (blank),
    .dsel_o  (dsel_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   phase_q <= PH_SECOND;
    else if (tick) phase_q <= phase_nxt;
  end

  // set has priority over acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             irq_q <= 1'b0;
    else if (tick && phase_nxt == PH_FIRST)  irq_q <= 1'b1;
    else if (irq_ack_i)                      irq_q <= 1'b0;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/disp_mux_ctrl_chk.sv
module disp_mux_ctrl_chk #(
  parameter int SEG_W  = 16,
  parameter int DIGITS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              phase_i,
  input logic              irq_ack_i,
  input logic [SEG_W-1:0]  seg_o,
  input logic [DIGITS-1:0] dsel_o,
  input logic              irq_o
);
  assert_sel_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dsel_o));

  assert_phase_flip_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (phase_i != $past(phase_i)));

  assert_blank_after_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (dsel_o == '0));

  assert_seg_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(seg_o));

  assert_irq_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && phase_i) |=> irq_o);

  assert_irq_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i) |=> irq_o);

  assert_irq_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !(tick_i && phase_i)) |=> !irq_o);
endmodule

bind disp_mux_ctrl disp_mux_ctrl_chk #(.SEG_W(SEG_W), .DIGITS(DIGITS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick),
  .phase_i   (phase_q),
  .irq_ack_i (irq_ack_i),
  .seg_o     (seg_o),
  .dsel_o    (dsel_o),
  .irq_o     (irq_o)
);

// File: tb/disp_mux_ctrl_bench.sv
module disp_mux_ctrl_bench;
  localparam int SEG_W  = 16;
  localparam int DIGITS = 8;
  localparam int DIV    = 16;
  localparam int BLANK  = 4;
  localparam int HB     = BLANK / 2;
  localparam int PW     = $clog2(DIGITS / 2);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic              wr_sel = 1'b0;
  logic [SEG_W-1:0]  wr_data = '0;
  logic [PW-1:0]     base = '0;
  logic              ack = 1'b0;
  logic [SEG_W-1:0]  seg;
  logic [DIGITS-1:0] dsel;
  logic              irq;

  int errors = 0;
  int checks = 0;
  int pos = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  disp_mux_ctrl #(.SEG_W(SEG_W), .DIGITS(DIGITS), .DIV(DIV), .BLANK(BLANK)) u_disp_mux_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wr_en_i     (wr_en),
    .wr_sel_i    (wr_sel),
    .wr_data_i   (wr_data),
    .base_pair_i (base),
    .irq_ack_i   (ack),
    .seg_o       (seg),
    .dsel_o      (dsel),
    .irq_o       (irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (pos %0d)", tag, act, exp, pos);
    end
  endtask

  task automatic step();
    @(negedge clk);
    pos = (pos + 1) % DIV;
  endtask

  task automatic go(input int target);
    step();
    while (pos != target) step();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [SEG_W-1:0] prev_a;
    logic [SEG_W-1:0] a;
    logic [SEG_W-1:0] bv;
    int prev_b;
    int guard;

    repeat (3) @(negedge clk);
    chk(seg == '0, "R1 seg in reset", 32'(seg), 0);
    chk(dsel == '0, "R1 dsel in reset", 32'(dsel), 0);
    chk(irq == 1'b0, "R1 irq in reset", 32'(irq), 0);
    rst_n = 1'b1;
    pos = 0;
    @(negedge clk);
    pos = 1;
    chk(seg == '0 && irq == 1'b0 && dsel == '0, "R1 after release",
        {15'd0, irq, 8'd0, dsel}, 0);

    // R2: first phase after reset is second-latch, first irq after DIV cycles
    go(0);
    chk(irq == 1'b1, "R2 R6 first irq at cycle DIV", 32'(irq), 1);

    prev_a = '0;
    prev_b = 0;
    for (int b = 0; b < DIGITS / 2; b++) begin
      for (int p = 0; p < 2; p++) begin
        a  = SEG_W'(16'h1234 * (b + 1) + p * 16'h8421);
        bv = ~a;
        // at first-latch phase, cycle 0
        chk(dsel == '0, "R5 blank at phase start", 32'(dsel), 0);
        ack = 1'b1;
        step();
        ack = 1'b0;
        chk(dsel == '0, "R5 blank at cycle 1", 32'(dsel), 0);
        chk(irq == 1'b0, "R7 ack clears irq", 32'(irq), 0);
        step();
        chk(dsel == (DIGITS'(1) << (2 * prev_b)), "R4 first digit of pair",
            32'(dsel), 32'(DIGITS'(1) << (2 * prev_b)));
        chk(seg == prev_a, "R3 first latch shown", 32'(seg), 32'(prev_a));
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = a;
        step();
        wr_sel = 1'b1; wr_data = bv;
        step();
        wr_en = 1'b0;
        base = PW'(b);
        step();
        chk(seg == prev_a, "R8 write mid-phase ignored", 32'(seg), 32'(prev_a));
        chk(dsel == (DIGITS'(1) << (2 * prev_b)), "R8 base change mid-phase ignored",
            32'(dsel), 32'(DIGITS'(1) << (2 * prev_b)));
        go(DIV - HB - 1);
        chk(dsel != '0, "R5 visible before end window", 32'(dsel), 1);
        step();
        chk(dsel == '0, "R5 blank at end of phase", 32'(dsel), 0);
        go(0);
        chk(seg == bv, "R3 second latch loaded at phase start", 32'(seg), 32'(bv));
        chk(dsel == '0 && irq == 1'b0, "R5 R6 blank and no irq in second phase",
            {15'd0, irq, 8'd0, dsel}, 0);
        go(HB);
        chk(dsel == (DIGITS'(1) << (2 * b + 1)), "R4 second digit of pair",
            32'(dsel), 32'(DIGITS'(1) << (2 * b + 1)));
        go(DIV - 1);
        chk(dsel == '0, "R5 blank at last cycle", 32'(dsel), 0);
        chk(seg == bv, "R3 second latch held for phase", 32'(seg), 32'(bv));
        go(0);
        chk(irq == 1'b1, "R6 irq at first-latch phase start", 32'(irq), 1);
        chk(seg == a, "R2 R3 phases alternate to first latch", 32'(seg), 32'(a));
        prev_a = a;
        prev_b = b;
      end
    end

    // R6: irq held without ack across a phase change
    go(5);
    go(5);
    chk(irq == 1'b1, "R6 irq held without ack", 32'(irq), 1);
    ack = 1'b1;
    step();
    ack = 1'b0;
    chk(irq == 1'b0, "R7 ack clears held irq", 32'(irq), 0);
    // R7: ack on the setting edge loses to the set
    go(DIV - 1);
    ack = 1'b1;
    step();
    ack = 1'b0;
    chk(irq == 1'b1, "R7 set wins over ack", 32'(irq), 1);
    guard = 0;
    step();
    chk(irq == 1'b1, "R7 irq still pending", 32'(irq), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule